// File: doc/BRIEF.md
# Rectangular Pixel-Area Address Walker

This block produces the byte addresses of one image layer's rectangular pixel area, one per pixel in raster order, toward a downstream memory port through a valid/ready handshake. The area is set by a base byte address, a pixel count per line, a line count, a pixel format code and a line gap counted in pixels. After the last pixel of a line, the gap is added to the line's width to find where the next line starts.

Software presents the configuration on the `cfg_*` inputs and pulses `start_req`. The block checks the configuration in that same cycle. A bad configuration raises a sticky error flag and nothing starts. An empty area completes at once. Otherwise every configuration value is latched and the walk begins. Configuration changes made while a walk runs have no effect. A suspend bit pauses address issue and an abort pulse ends the walk. The suspend bit clears by itself whenever the walk ends. Two sticky flags report completion and the end of a chosen line, the watermark. Each flag is cleared by writing a one to its bit of `flag_clr`.

The controller has three states. `ST_IDLE` waits for a start. `ST_ISSUE` offers addresses. `ST_PAUSE` holds off while suspended. The transitions are:
- `ST_IDLE` to `ST_ISSUE` on an accepted start.
- `ST_ISSUE` to `ST_PAUSE` when an address is taken while the suspend bit is set.
- `ST_PAUSE` to `ST_ISSUE` when the suspend bit clears.
- `ST_ISSUE` to `ST_IDLE` when the last address is taken.
- `ST_ISSUE` or `ST_PAUSE` to `ST_IDLE` on abort.

Top module: `rect_addr_gen`

## Requirements
- R1: After reset the block is idle. `busy`, `paused`, `addr_valid` and all three flags are 0.
- R2: Addresses are issued in raster order, starting at the base. Within a line the byte step is set by `cfg_fmt`: code 0 steps 4 bytes, code 1 steps 3, code 2 steps 2, and code 3 (4 bits per pixel) is described in R4.
- R3: The first address of each following line equals the previous line's first address plus (pixels per line + line gap) times the step. For code 3 this sum is halved instead.
- R4: With code 3 the address advances by one byte after every second pixel. Each address is therefore issued twice, once for each pixel of the pair.
- R5: A start is refused and `cfg_err_flag` is set when any of these holds:
  - code 0 with base bits [1:0] not zero;
  - code 2 with base bit 0 set;
  - code 3 with an odd pixel count or an odd line gap.
- R6: A valid start with zero pixels per line or zero lines issues no address and sets `done_flag` one cycle later, with `busy` staying 0.
- R7: `done_flag` is set on the edge at which the last address is accepted. `busy` falls on that same edge.
- R8: `wmark_flag` is set when the last pixel of line number `cfg_wmark` is accepted. Lines are counted from 1, so a value of 0 never fires.
- R9: Configuration is latched at an accepted start. Changing the `cfg_*` inputs, or pulsing `start_req`, while busy has no effect on the walk.
- R10: While `busy`, `susp_set` sets `paused` and `susp_clr` clears it. When `paused` is set, the walk stops after the address on offer is taken and `addr_valid` stays 0 until resume. `paused` clears whenever the walk ends.
- R11: `abort_req` while busy drops `addr_valid` in that cycle, returns the block to idle on the next edge, and clears `paused`. No completion flag is set.
- R12: `flag_clr` bit 0 clears `done_flag`, bit 1 clears `wmark_flag` and bit 2 clears `cfg_err_flag`. Flags otherwise hold.
- R13: Once `addr_valid` is high with `addr_ready` low, `addr_valid` and `addr` hold unchanged until accepted, unless an abort arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_base | input | 32 | Base byte address of the area |
| cfg_ppl | input | 14 | Pixels per line |
| cfg_lines | input | 16 | Number of lines |
| cfg_gap | input | 14 | Line gap in pixels added after each line |
| cfg_fmt | input | 2 | Pixel format code (0: 4 B, 1: 3 B, 2: 2 B, 3: 4 bit) |
| cfg_wmark | input | 16 | Watermark line number (from 1) |
| start_req | input | 1 | Start pulse |
| susp_set | input | 1 | Set the suspend bit |
| susp_clr | input | 1 | Clear the suspend bit |
| abort_req | input | 1 | Abort pulse |
| flag_clr | input | 3 | Write-one-to-clear for done, watermark, error |
| addr_valid | output | 1 | Address on offer |
| addr_ready | input | 1 | Downstream accepts the address |
| addr | output | 32 | Byte address of the current pixel |
| busy | output | 1 | Walk in progress |
| paused | output | 1 | Suspend bit |
| done_flag | output | 1 | Sticky transfer-complete flag |
| wmark_flag | output | 1 | Sticky watermark flag |
| cfg_err_flag | output | 1 | Sticky configuration-error flag |

## Verification
A wrong pixel or line counter shows up as a mismatched `addr` on the very next accepted handshake. It also moves the `done_flag` or `wmark_flag` edge, which is caught in that same cycle. A controller state that disagrees with the suspend or abort inputs shows as a wrong `addr_valid`, `busy` or `paused` within one clock of the input. The reference model is compared on every clock, so any divergence is reported in the cycle where it first reaches a port.

// File: rtl/rag_pkg.sv
package rag_pkg;

    typedef enum logic [1:0] {
        PF_WORD   = 2'd0,
        PF_TRIPLE = 2'd1,
        PF_HALF   = 2'd2,
        PF_NIBBLE = 2'd3
    } pix_fmt_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_PAUSE = 2'd2
    } walk_state_e;

endpackage

// File: rtl/rag_cfg_check.sv
module rag_cfg_check
    import rag_pkg::*;
#(
    parameter int AW = 32,
    parameter int PW = 14,
    parameter int LW = 16
) (
    input  logic [AW-1:0] base,
    input  logic [PW-1:0] ppl,
    input  logic [LW-1:0] nlines,
    input  logic [PW-1:0] gap,
    input  pix_fmt_e      fmt,
    output logic          cfg_bad,
    output logic          cfg_empty,
    output logic [AW-1:0] stride
);
    localparam int SW = PW + 1;

    logic [SW-1:0] span;
    logic [AW-1:0] span_w;

    assign span   = {1'b0, ppl} + {1'b0, gap};
    assign span_w = AW'(span);

    // stride in bytes between first pixels of consecutive lines
    always_comb begin
        unique case (fmt)
            PF_WORD:   stride = span_w << 2;
            PF_TRIPLE: stride = (span_w << 1) + span_w;
            PF_HALF:   stride = span_w << 1;
            PF_NIBBLE: stride = span_w >> 1;
            default:   stride = span_w;
        endcase
    end

    always_comb begin
        unique case (fmt)
            PF_WORD:   cfg_bad = (base[1:0] != 2'b00);
            PF_HALF:   cfg_bad = base[0];
            PF_NIBBLE: cfg_bad = ppl[0] | gap[0];
            default:   cfg_bad = 1'b0;
        endcase
    end

    assign cfg_empty = (ppl == '0) || (nlines == '0);

endmodule

// File: rtl/rag_walker.sv
module rag_walker
    import rag_pkg::*;
#(
    parameter int AW = 32,
    parameter int PW = 14,
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          fire,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] stride,
    input  logic [PW-1:0] ppl,
    input  logic [LW-1:0] nlines,
    input  logic [LW-1:0] wmark,
    input  pix_fmt_e      fmt,
    output logic [AW-1:0] addr,
    output logic          last_px,
    output logic          wm_hit
);
    logic [PW-1:0] ppl_q;
    logic [LW-1:0] nl_q;
    logic [LW-1:0] wm_q;
    logic [AW-1:0] stride_q;
    pix_fmt_e      fmt_q;
    logic [AW-1:0] line_q;
    logic [AW-1:0] cur_q;
    logic [PW-1:0] x_q;
    logic [LW-1:0] y_q;
    logic [AW-1:0] step;
    logic          eol;

    always_comb begin
        unique case (fmt_q)
            PF_WORD:   step = AW'(4);
            PF_TRIPLE: step = AW'(3);
            PF_HALF:   step = AW'(2);
            PF_NIBBLE: step = x_q[0] ? AW'(1) : AW'(0);
            default:   step = AW'(0);
        endcase
    end

    assign eol     = (x_q == ppl_q - PW'(1));
    assign last_px = eol && (y_q == nl_q - LW'(1));
    assign wm_hit  = fire && eol &&
                     (({1'b0, y_q} + (LW+1)'(1)) == {1'b0, wm_q});
    assign addr    = cur_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ppl_q    <= '0;
            nl_q     <= '0;
            wm_q     <= '0;
            stride_q <= '0;
            fmt_q    <= PF_WORD;
            line_q   <= '0;
            cur_q    <= '0;
            x_q      <= '0;
            y_q      <= '0;
        end else if (load) begin
            ppl_q    <= ppl;
            nl_q     <= nlines;
            wm_q     <= wmark;
            stride_q <= stride;
            fmt_q    <= fmt;
            line_q   <= base;
            cur_q    <= base;
            x_q      <= '0;
            y_q      <= '0;
        end else if (fire) begin
            if (eol) begin
                x_q    <= '0;
                y_q    <= y_q + LW'(1);
                line_q <= line_q + stride_q;
                cur_q  <= line_q + stride_q;
            end else begin
                x_q   <= x_q + PW'(1);
                cur_q <= cur_q + step;
            end
        end
    end

    // R2: inside a line, 4-byte pixels advance by exactly four
    assert_word_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fire && !eol && (fmt_q == PF_WORD) |=> addr == $past(addr) + AW'(4));

    // R4: first pixel of a nibble pair keeps the same byte address
    assert_nibble_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fire && !eol && (fmt_q == PF_NIBBLE) && !x_q[0] |=> $stable(addr));

endmodule

// File: rtl/rag_ctrl_fsm.sv
module rag_ctrl_fsm
    import rag_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_req,
    input  logic       susp_set,
    input  logic       susp_clr,
    input  logic       abort_req,
    input  logic [2:0] flag_clr,
    input  logic       cfg_bad,
    input  logic       cfg_empty,
    input  logic       addr_ready,
    input  logic       last_px,
    input  logic       wm_hit,
    output logic       load,
    output logic       fire,
    output logic       addr_valid,
    output logic       busy,
    output logic       paused,
    output logic       done_flag,
    output logic       wmark_flag,
    output logic       cfg_err_flag
);
    walk_state_e state_q, state_d;
    logic        susp_q;
    logic        done_q, wm_q, err_q;
    logic        start_ok, start_empty, start_bad;

    assign start_bad   = (state_q == ST_IDLE) && start_req && cfg_bad;
    assign start_empty = (state_q == ST_IDLE) && start_req && !cfg_bad && cfg_empty;
    assign start_ok    = (state_q == ST_IDLE) && start_req && !cfg_bad && !cfg_empty;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_ok) state_d = ST_ISSUE;
            end
            ST_ISSUE: begin
                if (abort_req)             state_d = ST_IDLE;
                else if (fire && last_px)  state_d = ST_IDLE;
                else if (fire && susp_q)   state_d = ST_PAUSE;
            end
            ST_PAUSE: begin
                if (abort_req)    state_d = ST_IDLE;
                else if (!susp_q) state_d = ST_ISSUE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        addr_valid = (state_q == ST_ISSUE) && !abort_req;
        fire       = addr_valid && addr_ready;
        load       = start_ok;
        busy       = (state_q != ST_IDLE);
        paused     = susp_q;
        done_flag  = done_q;
        wmark_flag = wm_q;
        cfg_err_flag = err_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            susp_q <= 1'b0;
            done_q <= 1'b0;
            wm_q   <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            if (state_d == ST_IDLE) susp_q <= 1'b0;
            else if (susp_set)      susp_q <= 1'b1;
            else if (susp_clr)      susp_q <= 1'b0;

            if ((fire && last_px) || start_empty) done_q <= 1'b1;
            else if (flag_clr[0])                 done_q <= 1'b0;

            if (wm_hit)            wm_q <= 1'b1;
            else if (flag_clr[1])  wm_q <= 1'b0;

            if (start_bad)         err_q <= 1'b1;
            else if (flag_clr[2])  err_q <= 1'b0;
        end
    end

    assert_cfg_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
        start_bad |=> cfg_err_flag && !busy);

    assert_empty_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        start_empty |=> done_flag && !busy);

    assert_last_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fire && last_px |=> done_flag && !busy);

    assert_abort_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        busy && abort_req |=> !busy && !paused);

    assert_susp_autoclear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy && (state_d == ST_IDLE) |=> !paused);

endmodule

// File: rtl/rect_addr_gen.sv
module rect_addr_gen
    import rag_pkg::*;
#(
    parameter int AW = 32,
    parameter int PW = 14,
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] cfg_base,
    input  logic [PW-1:0] cfg_ppl,
    input  logic [LW-1:0] cfg_lines,
    input  logic [PW-1:0] cfg_gap,
    input  logic [1:0]    cfg_fmt,
    input  logic [LW-1:0] cfg_wmark,
    input  logic          start_req,
    input  logic          susp_set,
    input  logic          susp_clr,
    input  logic          abort_req,
    input  logic [2:0]    flag_clr,
    output logic          addr_valid,
    input  logic          addr_ready,
    output logic [AW-1:0] addr,
    output logic          busy,
    output logic          paused,
    output logic          done_flag,
    output logic          wmark_flag,
    output logic          cfg_err_flag
);
    pix_fmt_e      fmt_in;
    logic          cfg_bad, cfg_empty;
    logic [AW-1:0] stride;
    logic          load, fire, last_px, wm_hit;

    assign fmt_in = pix_fmt_e'(cfg_fmt);

    rag_cfg_check #(.AW(AW), .PW(PW), .LW(LW)) u_check (
        .base      (cfg_base),
        .ppl       (cfg_ppl),
        .nlines    (cfg_lines),
        .gap       (cfg_gap),
        .fmt       (fmt_in),
        .cfg_bad   (cfg_bad),
        .cfg_empty (cfg_empty),
        .stride    (stride)
    );

    rag_walker #(.AW(AW), .PW(PW), .LW(LW)) u_walk (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .fire    (fire),
        .base    (cfg_base),
        .stride  (stride),
        .ppl     (cfg_ppl),
        .nlines  (cfg_lines),
        .wmark   (cfg_wmark),
        .fmt     (fmt_in),
        .addr    (addr),
        .last_px (last_px),
        .wm_hit  (wm_hit)
    );

    rag_ctrl_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_req    (start_req),
        .susp_set     (susp_set),
        .susp_clr     (susp_clr),
        .abort_req    (abort_req),
        .flag_clr     (flag_clr),
        .cfg_bad      (cfg_bad),
        .cfg_empty    (cfg_empty),
        .addr_ready   (addr_ready),
        .last_px      (last_px),
        .wm_hit       (wm_hit),
        .load         (load),
        .fire         (fire),
        .addr_valid   (addr_valid),
        .busy         (busy),
        .paused       (paused),
        .done_flag    (done_flag),
        .wmark_flag   (wmark_flag),
        .cfg_err_flag (cfg_err_flag)
    );

    // R13: an offered address is held until taken or aborted
    assert_valid_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid && !addr_ready |=> abort_req || (addr_valid && $stable(addr)));

    // R1: no address is offered while idle
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !addr_valid);

endmodule

// File: tb/sim_rect_addr_gen.sv
module sim_rect_addr_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg_base = '0;
    logic [13:0] cfg_ppl = '0;
    logic [15:0] cfg_lines = '0;
    logic [13:0] cfg_gap = '0;
    logic [1:0]  cfg_fmt = '0;
    logic [15:0] cfg_wmark = '0;
    logic        start_req = 1'b0, susp_set = 1'b0, susp_clr = 1'b0, abort_req = 1'b0;
    logic [2:0]  flag_clr = '0;
    logic        addr_ready = 1'b0;
    logic        addr_valid, busy, paused, done_flag, wmark_flag, cfg_err_flag;
    logic [31:0] addr;

    int checks = 0;
    int failures = 0;
    int rdy_mode = 0;
    int cyc = 0;

    // reference model state
    int          m_state = 0;   // 0 idle, 1 issuing, 2 paused
    bit          m_susp = 0, m_done = 0, m_wm = 0, m_err = 0;
    int          m_k = 0, m_ppl = 0, m_wmk = 0;
    logic [31:0] m_q[$];
    logic [31:0] acc[$];

    always #4 clk = ~clk;

    rect_addr_gen u0 (
        .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_ppl(cfg_ppl),
        .cfg_lines(cfg_lines), .cfg_gap(cfg_gap), .cfg_fmt(cfg_fmt),
        .cfg_wmark(cfg_wmark), .start_req(start_req), .susp_set(susp_set),
        .susp_clr(susp_clr), .abort_req(abort_req), .flag_clr(flag_clr),
        .addr_valid(addr_valid), .addr_ready(addr_ready), .addr(addr),
        .busy(busy), .paused(paused), .done_flag(done_flag),
        .wmark_flag(wmark_flag), .cfg_err_flag(cfg_err_flag)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        #1;
        cyc++;
        addr_ready <= (rdy_mode == 0) ? 1'b1 : cyc[0];
    end

    // behavioural reference, advanced on each clock edge
    always @(posedge clk) begin
        bit fire_m, bad, empty;
        int ns, bpp, stride;
        logic [31:0] a;
        if (!rst_n) begin
            m_state = 0; m_susp = 0; m_done = 0; m_wm = 0; m_err = 0;
            m_q.delete();
        end else begin
            fire_m = (m_state == 1) && !abort_req && addr_ready;
            ns = m_state;
            if (flag_clr[0]) m_done = 0;
            if (flag_clr[1]) m_wm = 0;
            if (flag_clr[2]) m_err = 0;
            case (m_state)
                0: if (start_req) begin
                    bad = (cfg_fmt == 0 && cfg_base[1:0] != 0) ||
                          (cfg_fmt == 2 && cfg_base[0]) ||
                          (cfg_fmt == 3 && (cfg_ppl[0] || cfg_gap[0]));
                    empty = (cfg_ppl == 0) || (cfg_lines == 0);
                    if (bad) m_err = 1;
                    else if (empty) m_done = 1;
                    else begin
                        bpp = (cfg_fmt == 0) ? 4 : (cfg_fmt == 1) ? 3 : 2;
                        stride = (cfg_fmt == 3) ? (cfg_ppl + cfg_gap) / 2
                                                : (cfg_ppl + cfg_gap) * bpp;
                        m_q.delete();
                        for (int l = 0; l < cfg_lines; l++)
                            for (int p = 0; p < cfg_ppl; p++) begin
                                a = cfg_base + 32'(l * stride) +
                                    32'((cfg_fmt == 3) ? p / 2 : p * bpp);
                                m_q.push_back(a);
                            end
                        m_k = 0; m_ppl = cfg_ppl; m_wmk = cfg_wmark;
                        ns = 1;
                    end
                end
                1: if (abort_req) begin ns = 0; m_q.delete(); end
                   else if (fire_m) begin
                       void'(m_q.pop_front());
                       m_k++;
                       if (m_k % m_ppl == 0 && m_k / m_ppl == m_wmk) m_wm = 1;
                       if (m_q.size() == 0) begin m_done = 1; ns = 0; end
                       else if (m_susp) ns = 2;
                   end
                2: if (abort_req) begin ns = 0; m_q.delete(); end
                   else if (!m_susp) ns = 1;
                default: ns = 0;
            endcase
            if (ns == 0) m_susp = 0;
            else if (susp_set) m_susp = 1;
            else if (susp_clr) m_susp = 0;
            m_state = ns;
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            check("R10/R11/R13 addr_valid", 32'(addr_valid),
                  32'((m_state == 1) && !abort_req));
            if (addr_valid && m_state == 1 && m_q.size() > 0)
                check("R2 addr", addr, m_q[0]);
            check("R11 busy", 32'(busy), 32'(m_state != 0));
            check("R10 paused", 32'(paused), 32'(m_susp));
            check("R7 done_flag", 32'(done_flag), 32'(m_done));
            check("R8 wmark_flag", 32'(wmark_flag), 32'(m_wm));
            check("R5 cfg_err_flag", 32'(cfg_err_flag), 32'(m_err));
            if (addr_valid && addr_ready) acc.push_back(addr);
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic set_cfg(input logic [31:0] b, input int ppl, input int nl,
                           input int gap, input int fmt, input int wm);
        cfg_base = b; cfg_ppl = 14'(ppl); cfg_lines = 16'(nl);
        cfg_gap = 14'(gap); cfg_fmt = 2'(fmt); cfg_wmark = 16'(wm);
    endtask

    task automatic clear_all();
        tick(1); flag_clr = 3'b111; tick(1); flag_clr = 3'b000;
        acc.delete();
    endtask

    task automatic kick();
        tick(1); start_req = 1'b1; tick(1); start_req = 1'b0;
    endtask

    task automatic wait_idle();
        while (m_state != 0) @(posedge clk);
        tick(2);
        @(negedge clk);
    endtask

    initial begin
        fork
            begin
                tick(3);
                @(negedge clk);
                check("R1 busy", 32'(busy), 0);
                check("R1 addr_valid", 32'(addr_valid), 0);
                check("R1 flags", {29'd0, done_flag, wmark_flag, cfg_err_flag}, 0);
                rst_n = 1'b1;

                // 4-byte pixels, always ready
                rdy_mode = 0; clear_all();
                set_cfg(32'h1000, 3, 2, 2, 0, 0);
                kick(); wait_idle();
                check("R3 line wrap addr", acc[3], 32'h1014);
                check("R7 done after area", 32'(done_flag), 1);
                check("R8 watermark 0 never fires", 32'(wmark_flag), 0);

                // 3-byte pixels, toggling ready
                rdy_mode = 1; clear_all();
                set_cfg(32'h2001, 2, 3, 1, 1, 3);
                kick(); wait_idle();
                check("R2 triple count", acc.size(), 6);
                check("R3 triple line", acc[2], 32'h2001 + 9);
                check("R8 watermark last line", 32'(wmark_flag), 1);

                // 2-byte pixels with watermark on line 1
                clear_all();
                set_cfg(32'h3002, 4, 2, 0, 2, 1);
                kick(); wait_idle();
                check("R2 half step", acc[1], 32'h3004);
                check("R8 watermark line 1", 32'(wmark_flag), 1);

                // 4-bit pixels
                rdy_mode = 0; clear_all();
                set_cfg(32'h4003, 4, 3, 2, 3, 2);
                kick(); wait_idle();
                check("R4 nibble pair", acc[1], 32'h4003);
                check("R4 nibble step", acc[2], 32'h4004);
                check("R4 nibble next line", acc[4], 32'h4006);

                // configuration errors
                clear_all(); set_cfg(32'h1002, 2, 2, 0, 0, 0); kick(); tick(2);
                @(negedge clk);
                check("R5 misaligned word", {30'd0, cfg_err_flag, busy}, 32'h2);
                clear_all(); set_cfg(32'h3001, 2, 2, 0, 2, 0); kick(); tick(2);
                check("R5 misaligned half", 32'(cfg_err_flag), 1);
                clear_all(); set_cfg(32'h4000, 3, 2, 0, 3, 0); kick(); tick(2);
                check("R5 odd nibble count", 32'(cfg_err_flag), 1);
                clear_all(); set_cfg(32'h4000, 2, 2, 1, 3, 0); kick(); tick(2);
                check("R5 odd nibble gap", 32'(cfg_err_flag), 1);
                check("R5 no addresses", acc.size(), 0);
                flag_clr = 3'b011; tick(1); flag_clr = 3'b000; tick(1);
                check("R12 unselected flag holds", 32'(cfg_err_flag), 1);

                // empty areas
                clear_all(); set_cfg(32'h5000, 0, 4, 0, 0, 0); kick(); tick(1);
                @(negedge clk);
                check("R6 zero ppl done", {30'd0, done_flag, busy}, 32'h2);
                clear_all(); set_cfg(32'h5000, 4, 0, 0, 0, 0); kick(); tick(2);
                check("R6 zero lines done", 32'(done_flag), 1);
                check("R6 no addresses", acc.size(), 0);
                flag_clr = 3'b001; tick(1); flag_clr = 3'b000; tick(1);
                check("R12 done cleared", 32'(done_flag), 0);

                // suspend, resume, config change and restart while busy
                clear_all(); set_cfg(32'h5000, 4, 3, 0, 2, 0);
                kick(); tick(2);
                susp_set = 1'b1; tick(1); susp_set = 1'b0;
                set_cfg(32'h9000, 1, 1, 0, 0, 0);
                start_req = 1'b1; tick(1); start_req = 1'b0;
                tick(3);
                @(negedge clk);
                check("R10 paused holds off", {30'd0, paused, addr_valid}, 32'h2);
                tick(1); susp_clr = 1'b1; tick(1); susp_clr = 1'b0;
                wait_idle();
                check("R9 latched count", acc.size(), 12);
                check("R9 latched last addr", acc[11], 32'h5016);

                // abort while paused
                rdy_mode = 1; clear_all(); set_cfg(32'h6000, 8, 8, 0, 0, 0);
                kick(); tick(6);
                susp_set = 1'b1; tick(1); susp_set = 1'b0; tick(4);
                abort_req = 1'b1; tick(1); abort_req = 1'b0; tick(1);
                @(negedge clk);
                check("R11 idle after abort", {30'd0, busy, paused}, 0);
                check("R11 no done", 32'(done_flag), 0);
                check("R11 partial", 32'(acc.size() < 64), 1);

                // abort while issuing
                clear_all(); kick(); tick(3);
                abort_req = 1'b1; tick(1); abort_req = 1'b0; tick(1);
                @(negedge clk);
                check("R11 abort in issue", 32'(busy), 0);
                tick(2);
            end
            begin
                repeat (150000) @(posedge clk);
                failures++;
                $display("FAIL watchdog expired");
            end
        join_any
        disable fork;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule